// File: doc/BRIEF.md
# CAN Transmit Mailbox Request and Status Controller

This block owns the control and status byte of a single CAN transmit mailbox and follows that mailbox through three states: empty, pending and on the bus. Software uses a byte-wide register port to raise a transmit request, to ask for an abort, and to acknowledge a finished request. A CAN protocol engine sees a pending request, reports when it starts an attempt, and reports how each attempt ended: success, arbitration lost or error.

The block exports a mailbox-empty flag and a write enable for the payload registers, which are writable only while the mailbox is empty. It also exports the completion and success bits that a shared transmit status register mirrors. When an attempt fails and no abort is waiting, the request stays pending so that the engine retries it. An abort raised during an attempt waits for that attempt to end, and if the attempt succeeds the success is reported.

Top module: `txmb_status_ctrl`

## Requirements
- R1: After reset the register reads 00h, and bits 7:6 read 0 whatever is written to them.
- R2: Bit 0 (request) is set by a selected write with data bit 0 at 1 while the mailbox is empty. A write of 0, or a write without `reg_sel`, has no effect. Bit 0 reads 1 exactly while the mailbox is not empty.
- R3: Bit 1 (abort) is ignored while the mailbox is empty. When it is set while the mailbox is pending and no attempt is running, the next cycle empties the mailbox, clears bits 0 and 1, sets bit 2 and clears bit 3. Bits 4 and 5 keep their values.
- R4: Setting a new request clears bit 2 and also clears bits 3, 4 and 5.
- R5: A selected write with data bit 2 at 1 clears bits 2, 3, 4 and 5 together.
- R6: When an attempt ends, exactly one of bit 3 (OK), bit 4 (arbitration lost) and bit 5 (error) becomes 1. The choice follows `eng_result`: 0 is OK, 1 is arbitration lost, and 2 or 3 is error.
- R7: A successful attempt empties the mailbox, clears bit 0 and sets bits 2 and 3.
- R8: A failed attempt with no abort returns the mailbox to pending with bit 0 still set. `eng_req` is high only while the mailbox is pending and no abort is set.
- R9: An abort set during an attempt takes effect only when that attempt ends. If the attempt succeeds, success is reported (bit 3 at 1). If the attempt fails, the mailbox empties with bit 2 at 1 and bit 3 at 0.
- R10: If a write of 1 to bit 2 lands in the same cycle as a completion, the completion wins and bit 2 reads 1.
- R11: `gsr_rqcp` and `gsr_txok` equal bits 2 and 3 of the register. `payload_we_en` equals `mb_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register selected by the address decoder |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register read value |
| eng_req | output | 1 | Transmission request pending, offered to the engine |
| eng_start | input | 1 | Engine begins an attempt for this mailbox |
| eng_done | input | 1 | Engine ends the current attempt |
| eng_result | input | 2 | Attempt outcome: 0 OK, 1 arbitration lost, 2 or 3 error |
| mb_empty | output | 1 | Mailbox is empty |
| payload_we_en | output | 1 | Payload registers may be written |
| gsr_rqcp | output | 1 | Request-completed bit for the global status register |
| gsr_txok | output | 1 | Transmit-OK bit for the global status register |

## Verification
A wrong state register appears one cycle later as a mismatch between bit 0, `mb_empty` and `eng_req`: the engine could be offered a mailbox that reads empty, or a retry could be missing after a lost arbitration. A wrong result flag or completion bit appears on the cycle after the attempt ends, both in the register and on the global status mirrors. The abort-during-attempt cases and the same-cycle clear-versus-completion case are driven on purpose, because an error there shows only in that single cycle.

// File: rtl/txmb_pkg.sv
// Shared types for the transmit mailbox controller.
package txmb_pkg;
    localparam int REG_W = 8;

    // Mailbox life cycle.
    typedef enum logic [1:0] {
        MB_EMPTY   = 2'd0,
        MB_PENDING = 2'd1,
        MB_ONBUS   = 2'd2
    } mb_state_t;

    // Engine outcome codes.
    localparam logic [1:0] RES_OK  = 2'd0;
    localparam logic [1:0] RES_ARB = 2'd1;

    // Bit positions in the control/status byte (software visible).
    localparam int B_REQ   = 0;
    localparam int B_ABORT = 1;
    localparam int B_DONE  = 2;
    localparam int B_OK    = 3;
    localparam int B_ARB   = 4;
    localparam int B_ERR   = 5;

    // Result flag group.
    typedef struct packed {
        logic err;
        logic arb;
        logic ok;
        logic done;
    } mb_flags_t;
endpackage

// File: rtl/txmb_regif.sv
// Register port decode for the mailbox control/status byte.
// Assumes one register location selected by reg_sel; reads are combinational.
module txmb_regif
    import txmb_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         reg_sel,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    input  logic         req_bit,
    input  logic         abort_bit,
    input  mb_flags_t    flags,
    output logic         sw_set_req,
    output logic         sw_set_abort,
    output logic         sw_clr_done,
    output logic [W-1:0] rdata
);
    logic wr_hit;

    // Qualify write strobes with the select.
    always_comb begin
        wr_hit       = reg_sel && reg_wr;
        sw_set_req   = wr_hit && reg_wdata[B_REQ];
        sw_set_abort = wr_hit && reg_wdata[B_ABORT];
        sw_clr_done  = wr_hit && reg_wdata[B_DONE];
    end

    // Assemble the read value; unused upper bits read zero.
    always_comb begin
        rdata          = '0;
        rdata[B_REQ]   = req_bit;
        rdata[B_ABORT] = abort_bit;
        rdata[B_DONE]  = flags.done;
        rdata[B_OK]    = flags.ok;
        rdata[B_ARB]   = flags.arb;
        rdata[B_ERR]   = flags.err;
    end
endmodule

// File: rtl/txmb_fsm.sv
// Mailbox state tracker: empty, pending, on the bus.
// Assumes eng_start arrives only while eng_req is high, and eng_done only
// while an attempt is running.
module txmb_fsm
    import txmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_set_req,
    input  logic       sw_set_abort,
    input  logic       eng_start,
    input  logic       eng_done,
    input  logic [1:0] eng_result,
    output mb_state_t  state,
    output logic       abort_q,
    output logic       evt_new_req,
    output logic       evt_attempt_end,
    output logic       evt_complete,
    output logic       evt_abort_idle
);
    mb_state_t state_d;
    logic      abort_d;
    logic      res_ok;

    // Decode the events of this cycle.
    always_comb begin
        res_ok          = (eng_result == RES_OK);
        evt_new_req     = (state == MB_EMPTY) && sw_set_req;
        evt_abort_idle  = (state == MB_PENDING) && abort_q;
        evt_attempt_end = (state == MB_ONBUS) && eng_done;
        evt_complete    = evt_abort_idle || (evt_attempt_end && (res_ok || abort_q));
    end

    // Next state and abort flag.
    always_comb begin
        state_d = state;
        abort_d = abort_q;
        if (state != MB_EMPTY && sw_set_abort) begin
            abort_d = 1'b1;
        end
        unique case (state)
            MB_EMPTY:   if (sw_set_req) state_d = MB_PENDING;
            MB_PENDING: begin
                if (abort_q)        state_d = MB_EMPTY;
                else if (eng_start) state_d = MB_ONBUS;
            end
            MB_ONBUS:   if (eng_done) state_d = evt_complete ? MB_EMPTY : MB_PENDING;
            default:    state_d = MB_EMPTY;
        endcase
        if (state_d == MB_EMPTY) begin
            abort_d = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= MB_EMPTY;
            abort_q <= 1'b0;
        end else begin
            state   <= state_d;
            abort_q <= abort_d;
        end
    end
endmodule

// File: rtl/txmb_status.sv
// Result flags: completion, OK, arbitration lost, error.
// Hardware completion takes priority over a software clear in the same cycle.
module txmb_status
    import txmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_clr_done,
    input  logic       evt_new_req,
    input  logic       evt_attempt_end,
    input  logic       evt_complete,
    input  logic       evt_abort_idle,
    input  logic [1:0] eng_result,
    output mb_flags_t  flags
);
    mb_flags_t flags_d;

    // Next flag values by event priority.
    always_comb begin
        flags_d = flags;
        if (sw_clr_done || evt_new_req) begin
            flags_d = '0;
        end
        if (evt_attempt_end) begin
            flags_d.ok  = (eng_result == RES_OK);
            flags_d.arb = (eng_result == RES_ARB);
            flags_d.err = (eng_result[1] == 1'b1);
        end
        if (evt_abort_idle) begin
            flags_d.ok  = 1'b0;
            flags_d.arb = flags.arb;
            flags_d.err = flags.err;
        end
        if (evt_complete) begin
            flags_d.done = 1'b1;
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_d;
    end
endmodule

// File: rtl/txmb_status_ctrl.sv
// Top: control/status register and pending state of one CAN transmit mailbox.
// Assumes the engine follows the eng_req / eng_start / eng_done handshake.
module txmb_status_ctrl
    import txmb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             eng_req,
    input  logic             eng_start,
    input  logic             eng_done,
    input  logic [1:0]       eng_result,
    output logic             mb_empty,
    output logic             payload_we_en,
    output logic             gsr_rqcp,
    output logic             gsr_txok
);
    logic      sw_set_req, sw_set_abort, sw_clr_done;
    logic      abort_q, evt_new_req, evt_attempt_end, evt_complete, evt_abort_idle;
    mb_state_t state;
    mb_flags_t flags;
    logic      req_bit;

    txmb_regif #(.W(REG_W)) u_regif (
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .req_bit(req_bit), .abort_bit(abort_q), .flags(flags),
        .sw_set_req(sw_set_req), .sw_set_abort(sw_set_abort),
        .sw_clr_done(sw_clr_done), .rdata(reg_rdata)
    );

    txmb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sw_set_req(sw_set_req), .sw_set_abort(sw_set_abort),
        .eng_start(eng_start), .eng_done(eng_done), .eng_result(eng_result),
        .state(state), .abort_q(abort_q),
        .evt_new_req(evt_new_req), .evt_attempt_end(evt_attempt_end),
        .evt_complete(evt_complete), .evt_abort_idle(evt_abort_idle)
    );

    txmb_status u_status (
        .clk(clk), .rst_n(rst_n),
        .sw_clr_done(sw_clr_done), .evt_new_req(evt_new_req),
        .evt_attempt_end(evt_attempt_end), .evt_complete(evt_complete),
        .evt_abort_idle(evt_abort_idle), .eng_result(eng_result),
        .flags(flags)
    );

    // Export state-derived outputs and global status mirrors.
    always_comb begin
        req_bit       = (state != MB_EMPTY);
        mb_empty      = (state == MB_EMPTY);
        payload_we_en = mb_empty;
        eng_req       = (state == MB_PENDING) && !abort_q;
        gsr_rqcp      = flags.done;
        gsr_txok      = flags.ok;
    end
endmodule

// File: rtl/txmb_checker.sv
// Port-level properties of the mailbox controller, bound to the top.
module txmb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       eng_req,
    input logic       eng_start,
    input logic       eng_done,
    input logic [1:0] eng_result,
    input logic       mb_empty,
    input logic       payload_we_en,
    input logic       gsr_rqcp,
    input logic       gsr_txok
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:6] == 2'b00);

    assert_req_vs_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] == !mb_empty);

    assert_abort_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_empty && reg_sel && reg_wr && reg_wdata[1]) |=> !reg_rdata[1]);

    assert_new_req_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[0]) |-> (reg_rdata[5:2] == 4'b0000));

    assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_wdata[2] && !eng_done) |=> (reg_rdata[5:2] == 4'b0000));

    assert_onehot_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_rdata[5:3]));

    assert_success_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && !eng_req && eng_done && eng_result == 2'd0)
        |=> (mb_empty && reg_rdata[2] && reg_rdata[3]));

    assert_req_only_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (!mb_empty && !reg_rdata[1]));

    assert_payload_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        payload_we_en |-> !reg_rdata[0]);
endmodule

bind txmb_status_ctrl txmb_checker u_txmb_checker (.*);

// File: tb/txmb_status_ctrl_bench.sv
// Scoreboard bench: driver pushes expected items, monitor compares after each edge.
module txmb_status_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_req, eng_start = 1'b0, eng_done = 1'b0;
    logic [1:0] eng_result = '0;
    logic       mb_empty, payload_we_en, gsr_rqcp, gsr_txok;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_run = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       empty;
        logic       req;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    txmb_status_ctrl u_txmb_status_ctrl (.*);

    // Monitor: compare every queued item shortly after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (reg_rdata !== e.rd || mb_empty !== e.empty || eng_req !== e.req
                    || payload_we_en !== e.empty || gsr_rqcp !== e.rd[2]
                    || gsr_txok !== e.rd[3]) begin
                    n_fail++;
                    $display("FAIL %s: rd=%02h empty=%b req=%b we=%b gsr=%b%b expected rd=%02h empty=%b req=%b",
                             e.tag, reg_rdata, mb_empty, eng_req, payload_we_en,
                             gsr_rqcp, gsr_txok, e.rd, e.empty, e.req);
                end
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue the post-edge expectation.
    task automatic step(input logic sel, input logic wr, input logic [7:0] wd,
                        input logic st, input logic dn, input logic [1:0] res,
                        input logic [7:0] erd, input logic eempty, input logic ereq,
                        input string tag);
        exp_t e;
        @(negedge clk);
        reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        eng_start = st; eng_done = dn; eng_result = res;
        e.rd = erd; e.empty = eempty; e.req = ereq; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0,0,8'h00, 0,0,0, 8'h00,1,0, "R1 reset state");
        step(1,1,8'hC2, 0,0,0, 8'h00,1,0, "R1 R3 upper bits and abort while empty");
        step(0,1,8'h01, 0,0,0, 8'h00,1,0, "R2 write without select");
        step(1,1,8'h01, 0,0,0, 8'h01,0,1, "R2 request set");
        step(1,1,8'h00, 0,0,0, 8'h01,0,1, "R2 write zero no effect");
        step(0,0,8'h00, 1,0,0, 8'h01,0,0, "R8 attempt started");
        step(0,0,8'h00, 0,1,1, 8'h11,0,1, "R6 R8 arbitration lost retry");
        step(0,0,8'h00, 1,0,0, 8'h11,0,0, "R8 retry started");
        step(0,0,8'h00, 0,1,2, 8'h21,0,1, "R6 error result");
        step(0,0,8'h00, 1,0,0, 8'h21,0,0, "R8 second retry");
        step(0,0,8'h00, 0,1,0, 8'h0C,1,0, "R7 R11 success");
        step(1,1,8'h04, 0,0,0, 8'h00,1,0, "R5 clear all flags");
        step(1,1,8'h01, 0,0,0, 8'h01,0,1, "R2 request again");
        step(0,0,8'h00, 1,0,0, 8'h01,0,0, "R8 attempt");
        step(0,0,8'h00, 0,1,3, 8'h21,0,1, "R6 code 3 is error");
        step(1,1,8'h02, 0,0,0, 8'h23,0,0, "R3 R8 abort set while pending");
        step(0,0,8'h00, 0,0,0, 8'h24,1,0, "R3 abort completes keeps error");
        step(1,1,8'h01, 0,0,0, 8'h01,0,1, "R4 new request clears flags");
        step(0,0,8'h00, 1,0,0, 8'h01,0,0, "R9 attempt");
        step(1,1,8'h02, 0,0,0, 8'h03,0,0, "R9 abort during attempt waits");
        step(0,0,8'h00, 0,1,0, 8'h0C,1,0, "R9 success wins over abort");
        step(1,1,8'h01, 0,0,0, 8'h01,0,1, "R4 request clears done and ok");
        step(0,0,8'h00, 1,0,0, 8'h01,0,0, "R9 attempt");
        step(1,1,8'h02, 0,0,0, 8'h03,0,0, "R9 abort during attempt");
        step(0,0,8'h00, 0,1,1, 8'h14,1,0, "R9 failure then abort completes");
        step(1,1,8'h01, 0,0,0, 8'h01,0,1, "R4 request");
        step(0,0,8'h00, 1,0,0, 8'h01,0,0, "R10 attempt");
        step(1,1,8'h04, 0,1,0, 8'h0C,1,0, "R10 completion beats clear");
        step(1,1,8'h04, 0,0,0, 8'h00,1,0, "R5 clear after completion");
        step(0,0,8'h00, 0,0,0, 8'h00,1,0, "R11 idle");
        @(negedge clk);
        @(negedge clk);
        done_run = 1'b1;
    end

    // Watchdog and final report.
    initial begin
        int cyc = 0;
        while (!done_run && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done_run) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule